// File: doc/BRIEF.md
# Dual-Buffer Gamma Crossfade Pixel Pipeline

This block sits between a host that loads picture data and an LED driver that wants linear 12-bit channel values. It keeps two banks of 8-bit channel codes. One bank is on screen and the host loads the other. When a frame is started, a sequencer walks the pixel addresses in order and reads the same address from both banks. Each code goes through a 256-entry table that the host can rewrite, which turns it into a 12-bit linear value. The two linear values are then mixed by a fade factor and dimmed by a global intensity.

The result leaves as a stream with a valid/ready handshake and a flag on the last value of each frame. The banks trade roles only when a frame starts, so one frame never mixes old and new roles. After reset the table holds a perceptual-lightness curve. The host may overwrite any entry while the pipeline is running.

Top module: `gamma_xfade_pipe`

## Requirements
- R1: After reset `out_valid` is 0 and `disp_sel` is 0. Table entry v is within one count of round(4095·Y), where L = 100·v/255, Y = L/903.3 when L ≤ 8, and Y = ((L+16)/116)³ otherwise.
- R2: A host pixel write (`pix_we`) stores `pix_wdata` at `pix_waddr` in the bank whose index is the inverse of `disp_sel`. The bank on display is unchanged.
- R3: A `swap_req` pulse is remembered. `disp_sel` inverts only in the cycle after the next accepted `frame_start`. A request made during a frame leaves that frame's reads and `disp_sel` untouched.
- R4: A `frame_start` pulse while a frame is still being read is ignored. That frame delivers exactly NPIX values and no second frame follows.
- R5: A frame delivers NPIX values in rising address order. `out_last` is 1 on the final value only.
- R6: A table write (`lut_we`) replaces entry `lut_waddr` with `lut_wdata`. Later reads of that code return the new value.
- R7: The mixed value is (A·(256−f) + B·f) >> 8. A is the table value of the code from bank `disp_sel`, B is the table value of the code from the other bank, and f = min(`fade`, 256). So f = 0 gives A only, and any `fade` of 256 or more gives B only.
- R8: The output is min(4095, (mix·(I + I[7]) + 128) >> 8), where I is `intensity`. I = 255 passes the mixed value unchanged.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values and no value is lost.
- R10: With `out_ready` held at 1, `out_valid` first rises after the third rising edge that follows the edge accepting `frame_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_we | input | 1 | Host pixel write strobe (hidden bank) |
| pix_waddr | input | AW | Pixel address for the host write |
| pix_wdata | input | CW | 8-bit channel code to store |
| swap_req | input | 1 | Request to exchange bank roles at the next frame start |
| lut_we | input | 1 | Table write strobe |
| lut_waddr | input | CW | Table entry to replace |
| lut_wdata | input | DW | New 12-bit linear value |
| fade | input | IW+1 | Fade factor, values above 256 clamp to 256 |
| intensity | input | IW | Global intensity, 255 is unity |
| frame_start | input | 1 | Start reading one frame |
| disp_sel | output | 1 | Index of the bank on display |
| out_valid | output | 1 | Output value present |
| out_ready | input | 1 | Downstream accepts the value |
| out_data | output | DW | 12-bit channel value for the driver |
| out_last | output | 1 | Marks the final value of a frame |

## Verification
The output stage uses `fade` and `intensity` as they stand when a value reaches it. The assertions on mixing and unity gain therefore assume both stay steady while a frame is in flight. The bench changes them only after a frame has fully drained.

Host pixel addresses are assumed to be below NPIX. Every write in the bench uses addresses 0 to NPIX−1.

Swap requests, restart pulses and back-pressure are the only inputs changed during a frame. Those are exactly the disturbances the hold, swap-timing and restart properties are written for.

// File: rtl/xfade_pkg.sv
package xfade_pkg;

  // Perceptual-lightness reset value for table entry `code` (8-bit in, 12-bit out).
  function automatic logic [11:0] cie_code(input int unsigned code);
    longint num;
    longint den;
    longint t;
    longint d;
    if (code <= 20) begin
      num = longint'(4095000) * longint'(code);
      den = longint'(2303415);
    end else begin
      t   = longint'(100 * code + 4080);
      d   = longint'(29580);
      num = longint'(4095) * t * t * t;
      den = d * d * d;
    end
    return 12'((num + den / 2) / den);
  endfunction

endpackage

// File: rtl/xfade_sequencer.sv
module xfade_sequencer #(
  parameter int NPIX = 8,
  localparam int AW = $clog2(NPIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          swap_req,
  input  logic          adv,
  output logic          issue,
  output logic [AW-1:0] rd_addr,
  output logic          issue_last,
  output logic          disp_sel
);
  localparam logic [AW-1:0] LAST = AW'(NPIX - 1);

  logic          busy_q, busy_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          sel_q, sel_d;
  logic          start_acc;

  always_comb begin
    start_acc  = start && !busy_q;
    issue      = busy_q && adv;
    issue_last = issue && (cnt_q == LAST);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    sel_d  = sel_q;
    if (start_acc) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      pend_d = 1'b0;
      if (pend_q || swap_req) sel_d = !sel_q;
    end else begin
      if (swap_req) pend_d = 1'b1;
      if (issue) begin
        if (cnt_q == LAST) begin
          busy_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      sel_q  <= sel_d;
    end
  end

  assign rd_addr  = cnt_q;
  assign disp_sel = sel_q;

  // R3: bank roles change only as a consequence of an accepted frame start
  assert_swap_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(start_acc));

  // R4: a restart pulse during a stalled frame leaves the frame position alone
  assert_restart_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !adv) |=> (busy_q && $stable(cnt_q)));

endmodule

// File: rtl/xfade_frame_store.sv
module xfade_frame_store #(
  parameter int NPIX = 8,
  parameter int CW   = 8,
  localparam int AW = $clog2(NPIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          front,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] a_code,
  output logic [CW-1:0] b_code
);
  logic [2*CW-1:0] bank_rd;
  logic [CW-1:0]   a_d, b_d;

  for (genvar bk = 0; bk < 2; bk++) begin : g_bank
    logic [CW-1:0] mem [NPIX];
    logic          bank_we;
    assign bank_we = wr_en && (wr_bank == 1'(bk)) && (32'(wr_addr) < NPIX);
    always_ff @(posedge clk) begin
      if (bank_we) mem[wr_addr] <= wr_data;
    end
    assign bank_rd[bk*CW +: CW] = mem[rd_addr];
  end

  always_comb begin
    a_d = a_code;
    b_d = b_code;
    if (rd_en) begin
      a_d = front ? bank_rd[CW +: CW] : bank_rd[0 +: CW];
      b_d = front ? bank_rd[0 +: CW]  : bank_rd[CW +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_code <= '0;
      b_code <= '0;
    end else begin
      a_code <= a_d;
      b_code <= b_d;
    end
  end

endmodule

// File: rtl/xfade_gamma_lut.sv
module xfade_gamma_lut #(
  parameter int CW = 8,
  parameter int DW = 12,
  localparam int DEPTH = 1 << CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          en,
  input  logic [CW-1:0] raddr_a,
  input  logic [CW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DEPTH*DW-1:0] tbl;
  logic [DW-1:0]       ra_d, rb_d;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    localparam logic [DW-1:0] INIT = DW'(xfade_pkg::cie_code(gi));
    logic [DW-1:0] ent_q, ent_d;
    always_comb ent_d = (we && (waddr == CW'(gi))) ? wdata : ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= INIT;
      else        ent_q <= ent_d;
    end
    assign tbl[gi*DW +: DW] = ent_q;
  end

  // Reads sample the table before a same-edge write lands, so they see the old entry.
  always_comb begin
    ra_d = en ? tbl[raddr_a*DW +: DW] : rdata_a;
    rb_d = en ? tbl[raddr_b*DW +: DW] : rdata_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_a <= '0;
      rdata_b <= '0;
    end else begin
      rdata_a <= ra_d;
      rdata_b <= rb_d;
    end
  end

  // R6: a written entry is what the next read of that code returns
  assert_lut_write_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && en && (raddr_a == $past(waddr))) |=> (rdata_a == $past(wdata, 2)));

endmodule

// File: rtl/xfade_blend_scale.sv
module xfade_blend_scale #(
  parameter int DW = 12,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [IW:0]   fade,
  input  logic [IW-1:0] intensity,
  output logic          out_valid,
  output logic          out_last,
  output logic [DW-1:0] out_data
);
  localparam int          MW   = DW + IW + 1;
  localparam int          PW   = DW + IW + 2;
  localparam logic [IW:0] FULL = (IW+1)'(1 << IW);
  localparam logic [DW-1:0] MAXV = '1;

  logic [IW:0]   f_eff, f_inv;
  logic [MW-1:0] mix_sum;
  logic [DW-1:0] mix;
  logic [IW:0]   gain;
  logic [PW-1:0] prod;
  logic [PW-1:0] scaled;
  logic [DW-1:0] sat;
  logic          v_d, l_d;
  logic [DW-1:0] o_d;

  always_comb begin
    f_eff   = (fade > FULL) ? FULL : fade;
    f_inv   = FULL - f_eff;
    mix_sum = MW'(a) * MW'(f_inv) + MW'(b) * MW'(f_eff);
    mix     = DW'(mix_sum >> IW);
    gain    = {1'b0, intensity} + (IW+1)'(intensity[IW-1]);
    prod    = PW'(mix) * PW'(gain) + PW'(1 << (IW - 1));
    scaled  = prod >> IW;
    sat     = (scaled > PW'(MAXV)) ? MAXV : DW'(scaled);
  end

  always_comb begin
    v_d = out_valid;
    l_d = out_last;
    o_d = out_data;
    if (adv) begin
      v_d = in_valid;
      l_d = in_last;
      o_d = sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v_d;
      out_last  <= l_d;
      out_data  <= o_d;
    end
  end

  // R7: a crossfade never leaves the span of its two sources
  assert_mix_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid) |-> ((mix >= ((a < b) ? a : b)) && (mix <= ((a < b) ? b : a))));

  // R8: full intensity is unity gain on the mixed value
  assert_unity_gain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid && (intensity == '1)) |=> (out_data == $past(mix)));

endmodule

// File: rtl/gamma_xfade_pipe.sv
module gamma_xfade_pipe #(
  parameter int NPIX = 8,
  parameter int CW   = 8,
  parameter int DW   = 12,
  parameter int IW   = 8,
  localparam int AW = $clog2(NPIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_we,
  input  logic [AW-1:0] pix_waddr,
  input  logic [CW-1:0] pix_wdata,
  input  logic          swap_req,
  input  logic          lut_we,
  input  logic [CW-1:0] lut_waddr,
  input  logic [DW-1:0] lut_wdata,
  input  logic [IW:0]   fade,
  input  logic [IW-1:0] intensity,
  input  logic          frame_start,
  output logic          disp_sel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic          adv;
  logic          issue, issue_last;
  logic [AW-1:0] rd_addr;
  logic [CW-1:0] a_code, b_code;
  logic [DW-1:0] a_lin, b_lin;
  logic          v1_q, v1_d, l1_q, l1_d;
  logic          v2_q, v2_d, l2_q, l2_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign adv = !out_valid || out_ready;

  xfade_sequencer #(.NPIX(NPIX)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(frame_start), .swap_req(swap_req),
    .adv(adv), .issue(issue), .rd_addr(rd_addr), .issue_last(issue_last),
    .disp_sel(disp_sel)
  );

  xfade_frame_store #(.NPIX(NPIX), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_i_n), .wr_en(pix_we), .wr_bank(!disp_sel),
    .wr_addr(pix_waddr), .wr_data(pix_wdata), .rd_en(adv), .front(disp_sel),
    .rd_addr(rd_addr), .a_code(a_code), .b_code(b_code)
  );

  xfade_gamma_lut #(.CW(CW), .DW(DW)) u_lut (
    .clk(clk), .rst_n(rst_i_n), .we(lut_we), .waddr(lut_waddr), .wdata(lut_wdata),
    .en(adv), .raddr_a(a_code), .raddr_b(b_code), .rdata_a(a_lin), .rdata_b(b_lin)
  );

  always_comb begin
    v1_d = adv ? issue      : v1_q;
    l1_d = adv ? issue_last : l1_q;
    v2_d = adv ? v1_q       : v2_q;
    l2_d = adv ? l1_q       : l2_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      v1_q <= 1'b0;
      l1_q <= 1'b0;
      v2_q <= 1'b0;
      l2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      l1_q <= l1_d;
      v2_q <= v2_d;
      l2_q <= l2_d;
    end
  end

  xfade_blend_scale #(.DW(DW), .IW(IW)) u_blend (
    .clk(clk), .rst_n(rst_i_n), .adv(adv), .in_valid(v2_q), .in_last(l2_q),
    .a(a_lin), .b(b_lin), .fade(fade), .intensity(intensity),
    .out_valid(out_valid), .out_last(out_last), .out_data(out_data)
  );

  // R9: a refused output value is held unchanged
  assert_hold_when_stalled_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R5: the last-of-frame flag only ever rides on a valid value
  assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_last |-> out_valid);

endmodule

// File: tb/test_gamma_xfade_pipe.sv
`timescale 1ns/1ps
module test_gamma_xfade_pipe;
  localparam int NPIX = 8;
  localparam int AW   = $clog2(NPIX);

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  b;
    logic [8:0]  f;
    logic [7:0]  g;
    logic [11:0] e;
    logic [3:0]  tag;
  } vec_t;

  // Table values are programmed as code*16, so A = a*16 and B = b*16.
  localparam vec_t VECS [10] = '{
    '{8'd100, 8'd200, 9'd0,   8'd255, 12'd1600, 4'd7},  // R7 fade 0: A only
    '{8'd100, 8'd200, 9'd256, 8'd255, 12'd3200, 4'd7},  // R7 fade 256: B only
    '{8'd100, 8'd200, 9'd300, 8'd255, 12'd3200, 4'd7},  // R7 clamp above 256
    '{8'd100, 8'd200, 9'd128, 8'd255, 12'd2400, 4'd7},  // R7 midpoint
    '{8'd255, 8'd0,   9'd64,  8'd255, 12'd3060, 4'd7},  // R7 quarter
    '{8'd200, 8'd200, 9'd77,  8'd128, 12'd1613, 4'd8},  // R8 half gain, rounding
    '{8'd100, 8'd0,   9'd0,   8'd0,   12'd0,    4'd8},  // R8 zero intensity
    '{8'd16,  8'd48,  9'd192, 8'd200, 12'd503,  4'd8},  // R8 mixed
    '{8'd1,   8'd3,   9'd1,   8'd255, 12'd16,   4'd7},  // R7 truncation
    '{8'd255, 8'd255, 9'd128, 8'd254, 12'd4064, 4'd8}   // R8 near full scale
  };

  localparam logic [7:0] CODES [NPIX] = '{8'd0, 8'd10, 8'd20, 8'd21, 8'd64, 8'd128, 8'd200, 8'd255};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          pix_we;
  logic [AW-1:0] pix_waddr;
  logic [7:0]    pix_wdata;
  logic          swap_req;
  logic          lut_we;
  logic [7:0]    lut_waddr;
  logic [11:0]   lut_wdata;
  logic [8:0]    fade;
  logic [7:0]    intensity;
  logic          frame_start;
  logic          disp_sel;
  logic          out_valid;
  logic          out_ready;
  logic [11:0]   out_data;
  logic          out_last;

  gamma_xfade_pipe i_gamma_xfade_pipe (
    .clk(clk), .rst_n(rst_n), .pix_we(pix_we), .pix_waddr(pix_waddr), .pix_wdata(pix_wdata),
    .swap_req(swap_req), .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
    .fade(fade), .intensity(intensity), .frame_start(frame_start), .disp_sel(disp_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int total = 0;
  int failed = 0;
  int cyc = 0;
  logic [11:0] got [NPIX];
  logic [11:0] ref_got [NPIX];
  int n_got;
  int lat;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failed++;
      total++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  function automatic int cie_ref(input int v);
    real l, y;
    l = 100.0 * v / 255.0;
    if (l <= 8.0) y = l / 903.3;
    else          y = ((l + 16.0) / 116.0) ** 3;
    return $rtoi(y * 4095.0 + 0.5);
  endfunction

  task automatic write_pix(input int addr, input int data);
    pix_we = 1'b1; pix_waddr = AW'(addr); pix_wdata = 8'(data);
    @(negedge clk);
    pix_we = 1'b0;
  endtask

  task automatic write_lut(input int addr, input int data);
    lut_we = 1'b1; lut_waddr = 8'(addr); lut_wdata = 12'(data);
    @(negedge clk);
    lut_we = 1'b0;
  endtask

  task automatic pulse_swap();
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
  endtask

  task automatic run_frame(input bit bp, input bit mid_swap, input bit mid_start);
    bit          prev_stall;
    logic [11:0] pd;
    logic        pl;
    bit          rdy;
    prev_stall = 1'b0; pd = '0; pl = 1'b0;
    n_got = 0;
    lat = -1;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i <= 40; i++) begin
      swap_req    = mid_swap && (i == 2);
      frame_start = mid_start && (i == 2);
      if (prev_stall)  // R9 hold while refused
        check(out_valid && (out_data == pd) && (out_last == pl), "R9", int'(out_data), int'(pd));
      if (out_valid && (lat < 0)) lat = i;
      rdy = bp ? ((i % 3) != 0) : 1'b1;
      out_ready = rdy;
      if (out_valid && rdy) begin
        if (n_got < NPIX) begin
          got[n_got] = out_data;
          // R5 last flag only on the final value
          check(out_last == (n_got == NPIX - 1), "R5", int'(out_last), int'(n_got == NPIX - 1));
        end
        n_got++;
      end
      prev_stall = out_valid && !rdy;
      pd = out_data;
      pl = out_last;
      @(negedge clk);
    end
    swap_req = 1'b0;
    frame_start = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; pix_we = 1'b0; pix_waddr = '0; pix_wdata = '0; swap_req = 1'b0;
    lut_we = 1'b0; lut_waddr = '0; lut_wdata = '0; fade = '0; intensity = 8'd255;
    frame_start = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(disp_sel == 1'b0, "R1", int'(disp_sel), 0);

    // Default curve through the pipeline, order and latency
    for (int k = 0; k < NPIX; k++) write_pix(k, CODES[k]);
    pulse_swap();
    run_frame(1'b0, 1'b0, 1'b0);
    check(disp_sel == 1'b1, "R3", int'(disp_sel), 1);
    check(n_got == NPIX, "R5", n_got, NPIX);
    check(lat == 3, "R10", lat, 3);
    for (int k = 0; k < NPIX; k++) begin
      int e;
      e = cie_ref(CODES[k]);
      check((int'(got[k]) >= e - 1) && (int'(got[k]) <= e + 1), "R1", int'(got[k]), e);
      ref_got[k] = got[k];
    end

    // R2 hidden bank writes leave the display alone
    for (int k = 0; k < NPIX; k++) write_pix(k, 255);
    run_frame(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < NPIX; k++) check(got[k] == ref_got[k], "R2", int'(got[k]), int'(ref_got[k]));

    // R6 table rewrite
    write_lut(128, 12'h123);
    run_frame(1'b0, 1'b0, 1'b0);
    check(got[5] == 12'h123, "R6", int'(got[5]), 'h123);
    check(got[4] == ref_got[4], "R6", int'(got[4]), int'(ref_got[4]));
    ref_got[5] = 12'h123;

    // R3 swap requested mid-frame waits for the next start
    run_frame(1'b0, 1'b1, 1'b0);
    check(disp_sel == 1'b1, "R3", int'(disp_sel), 1);
    check(got[0] == ref_got[0], "R3", int'(got[0]), int'(ref_got[0]));
    run_frame(1'b0, 1'b0, 1'b0);
    check(disp_sel == 1'b0, "R3", int'(disp_sel), 0);
    check(got[0] == 12'd4095, "R3", int'(got[0]), 4095);

    // R4 restart while busy is ignored
    run_frame(1'b0, 1'b0, 1'b1);
    check(n_got == NPIX, "R4", n_got, NPIX);
    check(got[NPIX-1] == 12'd4095, "R4", int'(got[NPIX-1]), 4095);

    // R9 back-pressure keeps order and values
    pulse_swap();
    run_frame(1'b0, 1'b0, 1'b0);
    run_frame(1'b1, 1'b0, 1'b0);
    check(n_got == NPIX, "R9", n_got, NPIX);
    for (int k = 0; k < NPIX; k++) check(got[k] == ref_got[k], "R9", int'(got[k]), int'(ref_got[k]));

    // Vector table: R7 and R8 with table = code*16
    for (int v = 0; v < 256; v++) write_lut(v, v * 16);
    for (int j = 0; j < 10; j++) begin
      bit ok;
      fade = '0; intensity = 8'd255;
      for (int k = 0; k < NPIX; k++) write_pix(k, VECS[j].a);
      pulse_swap();
      run_frame(1'b0, 1'b0, 1'b0);
      for (int k = 0; k < NPIX; k++) write_pix(k, VECS[j].b);
      fade = VECS[j].f; intensity = VECS[j].g;
      run_frame(1'b0, 1'b0, 1'b0);
      ok = (n_got == NPIX);
      for (int k = 0; k < NPIX; k++) if (got[k] != VECS[j].e) ok = 1'b0;
      check(ok, $sformatf("R%0d", VECS[j].tag), int'(got[0]), int'(VECS[j].e));
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule